// File: doc/BRIEF.md
# SIR Infrared Pulse Transmitter

This block turns a stream of bytes into the slow-rate (SIR) infrared transmit waveform. Each byte is sent as ten bit cells: a start bit (0), eight data bits with the least significant bit first, and a stop bit (1). Every cell that carries a 0 begins with one optical pulse. A cell that carries a 1 leaves the emitter dark. An external enable, `tick`, paces all timing. It runs at the pulse-clock rate, which is 8 MHz or 16 MHz as chosen by `clk_sel`. The block runs on a fast system clock and advances only on cycles where `tick` is high.

One prescaler, dividing by `baud_div+1`, produces a unit strobe. A bit cell lasts a fixed number of units. That number is the pulse-clock rate divided by 115200 and rounded: 69 at 8 MHz, 139 at 16 MHz. The pulse lasts `pulse_len+1` units. Both lengths scale with `baud_div`, so a fixed `pulse_len` gives a pulse that is a constant fraction of the bit time at every speed. For example, 12 at 8 MHz or 24 at 16 MHz gives roughly a 3/16-bit pulse. The speed setting, pulse length and clock select are captured when a byte is accepted. The polarity input is applied to the output directly.

Control is a four-state machine. **IDLE** drives `tx_ready` high; `tx_valid` with `tx_ready` moves to **START** (transition *accept*). **START** times the start bit and moves to **DATA** when its cell ends (*start_done*). **DATA** shifts out eight bits and moves to **STOP** after the last one (*data_done*). **STOP** times the dark stop cell and returns to **IDLE** (*stop_done*).

Top module: `sir_pulse_tx`

## Requirements
- R1: During and right after reset, `tx_ready` is 1 and `ir_tx` equals `tx_inv`, with no pulse.
- R2: A byte is taken on a rising clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is then 0 until the edge that completes the stop cell's last tick, and is 1 again from the next cycle.
- R3: The cells are sent in this order: start (0), `tx_data[0]` through `tx_data[7]`, then stop (1).
- R4: Each cell lasts U·(`baud_div`+1) ticks, where U is 69 when `clk_sel`=0 and 139 when `clk_sel`=1. With a tick on every cycle, one byte keeps `tx_ready` low for 10·U·(`baud_div`+1) cycles.
- R5: A 0 cell drives the line active from the first cycle of the cell. The line stays active for min(`pulse_len`+1, U)·(`baud_div`+1) ticks, so a pulse never extends past its own cell. The start pulse appears in the cycle after the accepting edge.
- R6: A 1 cell, including the stop cell, and the idle state keep the line inactive.
- R7: `ir_tx` is the line level XOR `tx_inv`, and it follows `tx_inv` at once. The active level is 1 when `tx_inv`=0.
- R8: `baud_div`, `pulse_len` and `clk_sel` are sampled on the accepting edge. Changes to them while a byte is in flight do not affect that byte.
- R9: On a cycle with `tick`=0 and no byte accepted, neither the line nor the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at the pulse-clock rate |
| clk_sel | input | 1 | Pulse clock: 0 = 8 MHz, 1 = 16 MHz |
| baud_div | input | 6 | Speed divider; bit rate = 115200/(baud_div+1) |
| pulse_len | input | 5 | Pulse length minus one, in prescaled units |
| tx_inv | input | 1 | Invert the transmit output |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte to send |
| tx_ready | output | 1 | Block can accept a byte |
| ir_tx | output | 1 | Infrared emitter drive |

## Verification
The assertions check five things on every cycle:
- the output rests at its inactive level whenever the block is ready or in the stop cell;
- an accepted byte raises the line on the very next cycle;
- nothing moves on a cycle without a tick;
- a pulse falls only on a tick;
- a byte ends only on a tick.

Only the bench's scenarios, compared cycle by cycle against an independent reference model, can show:
- the exact cell and pulse lengths under different speeds, clock selects and pulse settings;
- the LSB-first data order;
- back-to-back bytes;
- that settings changed mid-byte are ignored until the next byte.

// File: rtl/sir_tx_pkg.sv
package sir_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    // Prescaled units per bit cell: pulse-clock rate over the base bit rate, rounded.
    function automatic int unsigned cell_units(int unsigned clk_hz, int unsigned base_rate);
        return (clk_hz + base_rate / 2) / base_rate;
    endfunction

endpackage

// File: rtl/sir_prescaler.sv
module sir_prescaler #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_last,
    output logic             unit_stb
);

    logic [DIV_W-1:0] cnt_q;

    assign unit_stb = run && tick && (cnt_q == div_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            if (cnt_q == div_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sir_cell_timer.sv
module sir_cell_timer #(
    parameter int UNIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              unit_stb,
    input  logic [UNIT_W-1:0] cell_last,
    input  logic [UNIT_W-1:0] pulse_last,
    output logic              cell_done,
    output logic              pulse_end
);

    logic [UNIT_W-1:0] unit_q;

    assign cell_done = unit_stb && (unit_q == cell_last);
    assign pulse_end = unit_stb && (unit_q == pulse_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_q <= '0;
        end else if (clr) begin
            unit_q <= '0;
        end else if (unit_stb) begin
            if (unit_q == cell_last) begin
                unit_q <= '0;
            end else begin
                unit_q <= unit_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sir_cfg_latch.sv
module sir_cfg_latch #(
    parameter int DIV_W   = 6,
    parameter int PW_W    = 5,
    parameter int UNIT_W  = 8,
    parameter int UNIT_LO = 69,
    parameter int UNIT_HI = 139
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clk_sel,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [PW_W-1:0]   pw_in,
    output logic [DIV_W-1:0]  div_last,
    output logic [UNIT_W-1:0] cell_last,
    output logic [UNIT_W-1:0] pulse_last
);

    localparam logic [UNIT_W-1:0] LAST_LO = UNIT_W'(UNIT_LO - 1);
    localparam logic [UNIT_W-1:0] LAST_HI = UNIT_W'(UNIT_HI - 1);

    logic [UNIT_W-1:0] cell_sel;
    logic [UNIT_W-1:0] pw_ext;
    logic [UNIT_W-1:0] pw_fit;

    assign cell_sel = clk_sel ? LAST_HI : LAST_LO;
    assign pw_ext   = UNIT_W'(pw_in);

    generate
        if ((1 << PW_W) <= UNIT_LO) begin : g_no_clamp
            // Every pulse setting already fits inside the shortest cell.
            assign pw_fit = pw_ext;
        end else begin : g_clamp
            assign pw_fit = (pw_ext > cell_sel) ? cell_sel : pw_ext;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_last   <= '0;
            cell_last  <= LAST_LO;
            pulse_last <= '0;
        end else if (load) begin
            div_last   <= div_in;
            cell_last  <= cell_sel;
            pulse_last <= pw_fit;
        end
    end

endmodule

// File: rtl/sir_pulse_tx.sv
module sir_pulse_tx #(
    parameter int LO_CLK_HZ = 8_000_000,
    parameter int HI_CLK_HZ = 16_000_000,
    parameter int BASE_RATE = 115_200,
    parameter int DIV_W     = 6,
    parameter int PW_W      = 5,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clk_sel,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [PW_W-1:0]   pulse_len,
    input  logic              tx_inv,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ir_tx
);

    import sir_tx_pkg::*;

    localparam int UNIT_LO = int'(cell_units(LO_CLK_HZ, BASE_RATE));
    localparam int UNIT_HI = int'(cell_units(HI_CLK_HZ, BASE_RATE));
    localparam int UNIT_MX = (UNIT_HI > UNIT_LO) ? UNIT_HI : UNIT_LO;
    localparam int UNIT_W  = ($clog2(UNIT_MX + 1) > PW_W) ? $clog2(UNIT_MX + 1) : PW_W;
    localparam int IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_state_e         state_q;
    tx_state_e         state_d;
    logic [DATA_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;
    logic              line_q;
    logic              accept;
    logic              running;
    logic              unit_stb;
    logic              cell_done;
    logic              pulse_end;
    logic [DIV_W-1:0]  div_last;
    logic [UNIT_W-1:0] cell_last;
    logic [UNIT_W-1:0] pulse_last;

    assign tx_ready = (state_q == ST_IDLE);
    assign accept   = tx_ready && tx_valid;
    assign running  = (state_q != ST_IDLE);
    assign ir_tx    = line_q ^ tx_inv;

    sir_cfg_latch #(
        .DIV_W  (DIV_W),
        .PW_W   (PW_W),
        .UNIT_W (UNIT_W),
        .UNIT_LO(UNIT_LO),
        .UNIT_HI(UNIT_HI)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .clk_sel   (clk_sel),
        .div_in    (baud_div),
        .pw_in     (pulse_len),
        .div_last  (div_last),
        .cell_last (cell_last),
        .pulse_last(pulse_last)
    );

    sir_prescaler #(
        .DIV_W(DIV_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .run     (running),
        .tick    (tick),
        .div_last(div_last),
        .unit_stb(unit_stb)
    );

    sir_cell_timer #(
        .UNIT_W(UNIT_W)
    ) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .unit_stb  (unit_stb),
        .cell_last (cell_last),
        .pulse_last(pulse_last),
        .cell_done (cell_done),
        .pulse_end (pulse_end)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)                         state_d = ST_START;
            ST_START: if (cell_done)                      state_d = ST_DATA;
            ST_DATA:  if (cell_done && idx_q == IDX_LAST) state_d = ST_STOP;
            ST_STOP:  if (cell_done)                      state_d = ST_IDLE;
            default:                                      state_d = ST_IDLE;
        endcase
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            idx_q   <= '0;
            line_q  <= 1'b0;
        end else if (accept) begin
            shift_q <= tx_data;
            idx_q   <= '0;
            line_q  <= 1'b1;
        end else if (cell_done) begin
            unique case (state_q)
                ST_START: begin
                    line_q <= ~shift_q[0];
                end
                ST_DATA: begin
                    shift_q <= shift_q >> 1;
                    if (idx_q == IDX_LAST) begin
                        line_q <= 1'b0;
                    end else begin
                        idx_q  <= idx_q + 1'b1;
                        line_q <= ~shift_q[1];
                    end
                end
                ST_STOP: begin
                    line_q <= 1'b0;
                end
                default: begin
                    line_q <= 1'b0;
                end
            endcase
        end else if (pulse_end) begin
            line_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sir_pulse_tx_chk.sv
module sir_pulse_tx_chk (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  tx_valid,
    input logic                  tx_ready,
    input logic                  tx_inv,
    input logic                  ir_tx,
    input sir_tx_pkg::tx_state_e st,
    input logic                  line
);

    import sir_tx_pkg::*;

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (ir_tx == tx_inv)); // R6

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (line && !tx_ready && (ir_tx != tx_inv))); // R5

    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(tx_valid && tx_ready)) |=> ($stable(line) && $stable(st))); // R9

    AST_STOP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP) |-> !line); // R6

    AST_PULSE_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line) |-> $past(tick)); // R5

    AST_BYTE_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(tick)); // R4

endmodule

bind sir_pulse_tx sir_pulse_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_inv  (tx_inv),
    .ir_tx   (ir_tx),
    .st      (state_q),
    .line    (line_q)
);

// File: tb/sim_sir_pulse_tx.sv
module sim_sir_pulse_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       clk_sel = 1'b0;
    logic [5:0] baud_div = '0;
    logic [4:0] pulse_len = 5'd12;
    logic       tx_inv = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       ir_tx;

    int  n_checks = 0;
    int  n_fail = 0;
    int  tick_mode = 0;
    bit  tick_hold = 1'b0;
    bit  done = 1'b0;
    logic [7:0] lfsr = 8'hA7;

    always #5 clk = ~clk;

    sir_pulse_tx u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clk_sel  (clk_sel),
        .baud_div (baud_div),
        .pulse_len(pulse_len),
        .tx_inv   (tx_inv),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .ir_tx    (ir_tx)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Tick generator
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (tick_hold) tick = 1'b0;
            else case (tick_mode)
                0: tick = 1'b1;
                1: tick = (cyc % 3 == 0);
                2: tick = lfsr[0];
                default: tick = (cyc % 2 == 0);
            endcase
        end
    end

    // Reference model: tick-counted cells, independent of the design's counters
    bit m_idle = 1'b1;
    bit m_line = 1'b0;
    bit m_bits[10];
    int m_idx = 0;
    int m_t = 0;
    int m_cell = 0;
    int m_pw = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idle = 1'b1;
            m_line = 1'b0;
        end else if (m_idle) begin
            if (tx_valid) begin
                int u;
                int p;
                u = clk_sel ? 139 : 69;
                p = (int'(pulse_len) + 1 > u) ? u : int'(pulse_len) + 1;
                m_bits[0] = 1'b0;
                for (int i = 0; i < 8; i++) m_bits[i+1] = tx_data[i];
                m_bits[9] = 1'b1;
                m_cell = u * (int'(baud_div) + 1);
                m_pw   = p * (int'(baud_div) + 1);
                m_idx = 0;
                m_t = 0;
                m_line = 1'b1;
                m_idle = 1'b0;
            end
        end else if (tick) begin
            m_t++;
            if (m_t == m_pw) m_line = 1'b0;
            if (m_t == m_cell) begin
                m_t = 0;
                m_idx++;
                if (m_idx == 10) begin
                    m_idle = 1'b1;
                    m_line = 1'b0;
                end else begin
                    m_line = !m_bits[m_idx];
                end
            end
        end
    end

    // Per-cycle comparison, away from both edges
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            check(tx_ready == m_idle, "R2 ready", int'(tx_ready), int'(m_idle));
            check(ir_tx == (m_line ^ tx_inv), "R3 R4 R5 R6 R7 R8 ir_tx",
                  int'(ir_tx), int'(m_line ^ tx_inv));
        end
    end

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n_pulse;
        int n_busy;
        logic held;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(tx_ready == 1'b1, "R1 ready in reset", int'(tx_ready), 1);
        check(ir_tx == 1'b0, "R1 dark in reset", int'(ir_tx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b1, "R1 ready after reset", int'(tx_ready), 1);

        // R4 R5: nominal pulse at 8 MHz, full speed, tick every cycle
        tick_mode = 0; clk_sel = 0; baud_div = 0; pulse_len = 12; tx_inv = 0;
        @(negedge clk);
        tx_data = 8'hA5; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        n_pulse = 0; n_busy = 0;
        while (ir_tx != tx_inv) begin n_pulse++; n_busy++; @(negedge clk); end
        while (!tx_ready) begin n_busy++; @(negedge clk); end
        check(n_pulse == 13, "R5 start pulse length", n_pulse, 13);
        check(n_busy == 690, "R4 byte duration", n_busy, 690);

        // R7: inverted output, sparse ticks, slower speed, short pulse
        tx_inv = 1'b1; tick_mode = 1; baud_div = 1; pulse_len = 3;
        @(negedge clk);
        check(ir_tx == 1'b1, "R7 idle level inverted", int'(ir_tx), 1);
        send(8'h3C);
        wait_idle();

        // R8: settings changed mid-byte must not affect the byte in flight
        tx_inv = 1'b0; tick_mode = 0; clk_sel = 1; baud_div = 0; pulse_len = 24;
        send(8'h00);
        repeat (40) @(negedge clk);
        baud_div = 6'd5; pulse_len = 5'd2; clk_sel = 1'b0;
        // R2 R3: back-to-back byte queued while busy
        send(8'hFF);
        wait_idle();

        // R9: no tick means nothing moves
        tick_mode = 2; clk_sel = 0; baud_div = 2; pulse_len = 31;
        send(8'h96);
        repeat (200) @(negedge clk);
        tick_hold = 1'b1;
        @(negedge clk);
        held = ir_tx;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            check(ir_tx == held && tx_ready == 1'b0, "R9 frozen without tick",
                  int'(ir_tx), int'(held));
        end
        tick_hold = 1'b0;
        wait_idle();

        // R6: all-ones byte at slower rate: only the start pulse appears
        tick_mode = 3; baud_div = 3; pulse_len = 0;
        send(8'hFF);
        wait_idle();
        check(tx_ready == 1'b1 && ir_tx == 1'b0, "R6 dark after byte", int'(ir_tx), 0);

        finish_run();
    end

endmodule